// File: doc/BRIEF.md
# Lock Key and Status LED Controller

This block turns two debounced lock keys and a host-activity pulse into lock states, a turbo request and the drive levels for an LED output port. One key is a plain toggle. The other also toggles on each press. If it is held past a configurable time, that toggle is reversed and a turbo request is raised for as long as the key stays down. Both lock indicators and all status LED channels are active-low, so a 0 lights the LED.

Four RGB status LEDs are dimmed by pulse-width modulation, with one duty value per colour channel. All channels compare their duty value against one shared free-running counter. The wiring may reverse the LED order or swap the red and green lines, so a parameter-driven pin map sits between the logical channels and the output bits.

When no host frame has arrived for a set time, and also after reset, the block ignores the duty values. It then flashes the status LEDs red and blue at full brightness in an alternating pattern.

Top module: `lkled_ctrl`

## Requirements
- R1: Reset clears both lock states and turbo. Each 0-to-1 transition of `shift_key_i` (1 = pressed) inverts `shift_lock_o` one cycle later, and holding that key has no other effect.
- R2: Each 0-to-1 transition of `caps_key_i` inverts `caps_lock_o` one cycle later. A release before the hold time leaves the new state in place.
- R3: If `caps_key_i` stays high for HOLD_CYCLES cycles after the press edge, `caps_lock_o` returns to its state before the press, and `turbo_o` rises in that same cycle.
- R4: `turbo_o` stays high while the key is held, falls in the cycle after release, and is never high unless the key was high in the cycle before.
- R5: `shift_led_n_o` and `caps_led_n_o` are 0 exactly when the matching lock state is on.
- R6: A status channel with duty value d is lit (output 0) for exactly d out of every 2^PWM_W cycles. Duty 0 never lights the channel.
- R7: Logical LED l (0 to NUM_LED-1) with channel c (red 0, green 1, blue 2) drives output bit 3*p + k. Here p = NUM_LED-1-l when REVERSE_LEDS is set, else p = l. k swaps 0 and 1 when SWAP_RG is set, else k = c.
- R8: Host absence is declared SILENT_CYCLES cycles after the last cycle with `host_frame_i` high, and it also holds from reset. A single host frame ends it, after which the status LEDs follow their duty values again.
- R9: While the host is absent, each logical LED has exactly one lit channel. In phase 0, even-numbered LEDs show red and odd-numbered LEDs show blue. Phase 1 inverts this. Green is off in both phases. Phase 0 starts when absence begins, and the phase changes every FLASH_HALF_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_key_i | input | 1 | Debounced plain lock key, 1 = pressed |
| caps_key_i | input | 1 | Debounced lock/turbo key, 1 = pressed |
| host_frame_i | input | 1 | High in a cycle in which a valid host frame arrived |
| duty_i | input | NUM_LED*3*PWM_W | Duty values; logical channel 3*l+c occupies bits [(3*l+c)*PWM_W +: PWM_W] |
| shift_lock_o | output | 1 | Plain lock state |
| caps_lock_o | output | 1 | Caps lock state |
| turbo_o | output | 1 | Turbo request |
| shift_led_n_o | output | 1 | Plain lock indicator, active-low |
| caps_led_n_o | output | 1 | Caps lock indicator, active-low |
| rgb_n_o | output | NUM_LED*3 | Status LED channels after the pin map, active-low |

## Verification
The assertions take the key inputs to be clean, debounced levels that change at most once per cycle. They also take `host_frame_i` to be a synchronous level sampled at the clock. The flash check assumes the output register has had one cycle since reset before it looks at the LEDs. The stimulus changes every input only on the falling clock edge, and it keeps each key press long enough for the edge detector to see it. It holds the host pulse high continuously during the dimming tests, so that absence cannot start in the middle of a measurement window.

// File: rtl/lkled_pkg.sv
package lkled_pkg;

   localparam int CH_RED   = 0;
   localparam int CH_GREEN = 1;
   localparam int CH_BLUE  = 2;
   localparam int NUM_CH   = 3;

   typedef enum logic {
      PH_EVEN_RED  = 1'b0,
      PH_EVEN_BLUE = 1'b1
   } flash_phase_e;

   // Output bit that carries logical LED l, channel c, after the wiring map.
   function automatic int phys_bit(input int l, input int c, input int n_led,
                                   input bit reverse, input bit swap_rg);
      int p;
      int k;
      p = reverse ? (n_led - 1 - l) : l;
      k = c;
      if (swap_rg && c == CH_RED)   k = CH_GREEN;
      if (swap_rg && c == CH_GREEN) k = CH_RED;
      return p * NUM_CH + k;
   endfunction

endpackage

// File: rtl/lkled_lock_key.sv
module lkled_lock_key #(
   parameter bit HOLD_EN     = 1'b0,
   parameter int HOLD_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_i,
   output logic lock_o,
   output logic turbo_o
);

   logic key_q;
   logic lock_q;
   logic press;

   assign press  = key_i & ~key_q;
   assign lock_o = lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q <= 1'b0;
      else        key_q <= key_i;
   end

   generate
      if (HOLD_EN) begin : g_hold
         localparam int CW = $clog2(HOLD_CYCLES + 1);
         logic [CW-1:0] cnt_q;
         logic          long_q;

         if (HOLD_CYCLES < 1) begin : g_bad_hold
            $error("lkled_lock_key: HOLD_CYCLES must be at least 1");
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lock_q <= 1'b0;
               cnt_q  <= '0;
               long_q <= 1'b0;
            end else if (press) begin
               lock_q <= ~lock_q;
               cnt_q  <= CW'(1);
               long_q <= 1'b0;
            end else if (!key_i) begin
               cnt_q  <= '0;
               long_q <= 1'b0;
            end else if (!long_q) begin
               if (cnt_q == CW'(HOLD_CYCLES)) begin
                  long_q <= 1'b1;
                  lock_q <= ~lock_q;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         assign turbo_o = long_q;
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     lock_q <= 1'b0;
            else if (press) lock_q <= ~lock_q;
         end

         assign turbo_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/lkled_pwm.sv
module lkled_pwm #(
   parameter int PWM_W = 8,
   parameter int N_CH  = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_CH*PWM_W-1:0] duty_i,
   output logic [N_CH-1:0]       on_o
);

   logic [PWM_W-1:0] ramp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ramp_q <= '0;
      else        ramp_q <= ramp_q + 1'b1;
   end

   generate
      for (genvar k = 0; k < N_CH; k++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) on_o[k] <= 1'b0;
            else        on_o[k] <= (ramp_q < duty_i[k*PWM_W +: PWM_W]);
         end
      end
   endgenerate

endmodule

// File: rtl/lkled_host_watch.sv
module lkled_host_watch
   import lkled_pkg::*;
#(
   parameter int SILENT_CYCLES     = 1000,
   parameter int FLASH_HALF_CYCLES = 500
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_i,
   output logic         absent_o,
   output flash_phase_e phase_o
);

   localparam int SW = $clog2(SILENT_CYCLES + 1);
   localparam int FW = $clog2(FLASH_HALF_CYCLES + 1);

   logic [SW-1:0] silent_q;
   logic [FW-1:0] flash_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         absent_o <= 1'b1;
         silent_q <= '0;
      end else if (frame_i) begin
         absent_o <= 1'b0;
         silent_q <= '0;
      end else if (!absent_o) begin
         if (silent_q == SW'(SILENT_CYCLES - 1)) begin
            absent_o <= 1'b1;
            silent_q <= '0;
         end else begin
            silent_q <= silent_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flash_q <= '0;
         phase_o <= PH_EVEN_RED;
      end else if (!absent_o) begin
         flash_q <= '0;
         phase_o <= PH_EVEN_RED;
      end else if (flash_q == FW'(FLASH_HALF_CYCLES - 1)) begin
         flash_q <= '0;
         phase_o <= (phase_o == PH_EVEN_RED) ? PH_EVEN_BLUE : PH_EVEN_RED;
      end else begin
         flash_q <= flash_q + 1'b1;
      end
   end

endmodule

// File: rtl/lkled_pinmap.sv
module lkled_pinmap
   import lkled_pkg::*;
#(
   parameter int NUM_LED      = 4,
   parameter bit REVERSE_LEDS = 1'b0,
   parameter bit SWAP_RG      = 1'b0
) (
   input  logic [NUM_LED*NUM_CH-1:0] logical_i,
   output logic [NUM_LED*NUM_CH-1:0] phys_o
);

   generate
      for (genvar l = 0; l < NUM_LED; l++) begin : g_led
         for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam int PB = phys_bit(l, c, NUM_LED, REVERSE_LEDS, SWAP_RG);
            assign phys_o[PB] = logical_i[l*NUM_CH + c];
         end
      end
   endgenerate

endmodule

// File: rtl/lkled_ctrl.sv
module lkled_ctrl
   import lkled_pkg::*;
#(
   parameter int PWM_W             = 8,
   parameter int NUM_LED           = 4,
   parameter int HOLD_CYCLES       = 40_000_000,
   parameter int SILENT_CYCLES     = 20_000_000,
   parameter int FLASH_HALF_CYCLES = 10_000_000,
   parameter bit REVERSE_LEDS      = 1'b0,
   parameter bit SWAP_RG           = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          shift_key_i,
   input  logic                          caps_key_i,
   input  logic                          host_frame_i,
   input  logic [NUM_LED*3*PWM_W-1:0]    duty_i,
   output logic                          shift_lock_o,
   output logic                          caps_lock_o,
   output logic                          turbo_o,
   output logic                          shift_led_n_o,
   output logic                          caps_led_n_o,
   output logic [NUM_LED*3-1:0]          rgb_n_o
);

   localparam int N_CH = NUM_LED * NUM_CH;

   if (PWM_W < 1 || PWM_W > 16) begin : g_bad_pwm
      $error("lkled_ctrl: PWM_W must lie in 1..16");
   end
   if (NUM_LED < 1) begin : g_bad_led
      $error("lkled_ctrl: NUM_LED must be at least 1");
   end
   if (SILENT_CYCLES < 2 || FLASH_HALF_CYCLES < 1) begin : g_bad_time
      $error("lkled_ctrl: silence and flash intervals too short");
   end

   logic         shift_turbo_unused;
   logic         absent;
   flash_phase_e phase;
   logic [N_CH-1:0] pwm_on;
   logic [N_CH-1:0] flash_on;
   logic [N_CH-1:0] logical_on;
   logic [N_CH-1:0] phys_on;
   logic [N_CH-1:0] rgb_n_q;

   lkled_lock_key #(.HOLD_EN(1'b0), .HOLD_CYCLES(1)) u_shift (
      .clk(clk), .rst_n(rst_n), .key_i(shift_key_i),
      .lock_o(shift_lock_o), .turbo_o(shift_turbo_unused)
   );

   lkled_lock_key #(.HOLD_EN(1'b1), .HOLD_CYCLES(HOLD_CYCLES)) u_caps (
      .clk(clk), .rst_n(rst_n), .key_i(caps_key_i),
      .lock_o(caps_lock_o), .turbo_o(turbo_o)
   );

   assign shift_led_n_o = ~shift_lock_o;
   assign caps_led_n_o  = ~caps_lock_o;

   lkled_pwm #(.PWM_W(PWM_W), .N_CH(N_CH)) u_pwm (
      .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .on_o(pwm_on)
   );

   lkled_host_watch #(
      .SILENT_CYCLES(SILENT_CYCLES), .FLASH_HALF_CYCLES(FLASH_HALF_CYCLES)
   ) u_watch (
      .clk(clk), .rst_n(rst_n), .frame_i(host_frame_i),
      .absent_o(absent), .phase_o(phase)
   );

   generate
      for (genvar l = 0; l < NUM_LED; l++) begin : g_flash
         localparam bit EVEN = ((l % 2) == 0);
         logic red_on;
         assign red_on = EVEN ^ (phase == PH_EVEN_BLUE);
         assign flash_on[l*NUM_CH + CH_RED]   = red_on;
         assign flash_on[l*NUM_CH + CH_GREEN] = 1'b0;
         assign flash_on[l*NUM_CH + CH_BLUE]  = ~red_on;
      end
   endgenerate

   assign logical_on = absent ? flash_on : pwm_on;

   lkled_pinmap #(
      .NUM_LED(NUM_LED), .REVERSE_LEDS(REVERSE_LEDS), .SWAP_RG(SWAP_RG)
   ) u_map (
      .logical_i(logical_on), .phys_o(phys_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rgb_n_q <= '1;
      else        rgb_n_q <= ~phys_on;
   end

   assign rgb_n_o = rgb_n_q;

endmodule

// File: rtl/lkled_ctrl_chk.sv
module lkled_ctrl_chk #(
   parameter int NUM_LED = 4,
   parameter int N_OUT   = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shift_key_i,
   input logic             caps_key_i,
   input logic             host_frame_i,
   input logic             shift_lock_o,
   input logic             caps_lock_o,
   input logic             turbo_o,
   input logic [N_OUT-1:0] rgb_n_o,
   input logic             host_absent
);

   a_r1_shift_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_key_i && !$past(shift_key_i)) |=> (shift_lock_o != $past(shift_lock_o)));

   a_r1_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_key_i && !$past(shift_key_i)) |=> $stable(shift_lock_o));

   a_r2_caps_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (caps_key_i && !$past(caps_key_i)) |=> (caps_lock_o != $past(caps_lock_o)));

   a_r3_turbo_undo: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(turbo_o) |-> (caps_lock_o != $past(caps_lock_o)));

   a_r4_turbo_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      turbo_o |-> $past(caps_key_i));

   a_r8_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
      host_frame_i |=> !host_absent);

   a_r9_one_per_led: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(host_absent)) |-> ($countones(~rgb_n_o) == NUM_LED));

endmodule

bind lkled_ctrl lkled_ctrl_chk #(.NUM_LED(NUM_LED), .N_OUT(NUM_LED*3)) u_chk (
   .clk(clk), .rst_n(rst_n), .shift_key_i(shift_key_i), .caps_key_i(caps_key_i),
   .host_frame_i(host_frame_i), .shift_lock_o(shift_lock_o),
   .caps_lock_o(caps_lock_o), .turbo_o(turbo_o), .rgb_n_o(rgb_n_o),
   .host_absent(absent)
);

// File: tb/tb_lkled_ctrl.sv
module tb_lkled_ctrl;

   localparam int NL     = 4;
   localparam int NC     = NL * 3;
   localparam int HOLD   = 20;
   localparam int SILENT = 200;
   localparam int FHALF  = 50;
   localparam int NTAB   = 6;
   localparam int DUTY_TAB [NTAB] = '{0, 1, 77, 128, 200, 255};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_key = 1'b0;
   logic caps_key = 1'b0;
   logic host_frame = 1'b0;
   logic [NC*8-1:0] duty = '0;
   logic shift_lock, caps_lock, turbo, shift_led_n, caps_led_n;
   logic [NC-1:0] rgb_n;

   int n_chk = 0;
   int n_fail = 0;
   int lit [NC];
   bit done = 1'b0;

   always #2 clk = ~clk;

   lkled_ctrl #(
      .PWM_W(8), .NUM_LED(NL), .HOLD_CYCLES(HOLD), .SILENT_CYCLES(SILENT),
      .FLASH_HALF_CYCLES(FHALF), .REVERSE_LEDS(1'b1), .SWAP_RG(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .shift_key_i(shift_key), .caps_key_i(caps_key),
      .host_frame_i(host_frame), .duty_i(duty), .shift_lock_o(shift_lock),
      .caps_lock_o(caps_lock), .turbo_o(turbo), .shift_led_n_o(shift_led_n),
      .caps_led_n_o(caps_led_n), .rgb_n_o(rgb_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R7 mapping with REVERSE_LEDS=1, SWAP_RG=1
   function automatic int pbit(input int l, input int c);
      int k;
      k = (c == 0) ? 1 : (c == 1) ? 0 : c;
      return (NL - 1 - l) * 3 + k;
   endfunction

   // R9 expected active-low flash pattern
   function automatic logic [NC-1:0] flash_exp(input bit phase);
      logic [NC-1:0] v;
      v = '1;
      for (int l = 0; l < NL; l++) begin
         bit red;
         red = ((l % 2) == 0) ^ phase;
         if (red) v[pbit(l, 0)] = 1'b0;
         else     v[pbit(l, 2)] = 1'b0;
      end
      return v;
   endfunction

   task automatic measure();
      for (int k = 0; k < NC; k++) lit[k] = 0;
      repeat (256) begin
         @(negedge clk);
         for (int k = 0; k < NC; k++) if (!rgb_n[k]) lit[k]++;
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick(3);
      chk("R1 reset shift lock", shift_lock, 0);
      chk("R1 reset caps lock", caps_lock, 0);
      chk("R1 reset turbo", turbo, 0);
      chk("R5 reset shift led", shift_led_n, 1);
      chk("R5 reset caps led", caps_led_n, 1);
      rst_n = 1'b1;

      // host absent from reset: flash phase 0 then phase 1
      tick(5);
      chk("R9 flash phase0 after reset", int'(rgb_n), int'(flash_exp(1'b0)));
      tick(50);
      chk("R9 flash phase1", int'(rgb_n), int'(flash_exp(1'b1)));

      // PWM table walk, host present
      host_frame = 1'b1;
      for (int i = 0; i < NTAB; i++) begin
         for (int k = 0; k < NC; k++) duty[k*8 +: 8] = 8'(DUTY_TAB[i]);
         tick(4);
         measure();
         for (int k = 0; k < NC; k++) chk("R6 pwm duty", lit[k], DUTY_TAB[i]);
      end

      // R7 distinct duty per logical channel
      for (int k = 0; k < NC; k++) duty[k*8 +: 8] = 8'(10 + 15 * k);
      tick(4);
      measure();
      for (int l = 0; l < NL; l++)
         for (int c = 0; c < 3; c++)
            chk("R7 channel map", lit[pbit(l, c)], 10 + 15 * (l * 3 + c));

      // R1 / R5 shift lock
      shift_key = 1'b1; tick(2); shift_key = 1'b0; tick(2);
      chk("R1 shift on", shift_lock, 1);
      chk("R5 shift led lit", shift_led_n, 0);
      shift_key = 1'b1; tick(40);
      chk("R1 shift second press off", shift_lock, 0);
      chk("R1 shift hold no turbo", turbo, 0);
      shift_key = 1'b0; tick(2);
      chk("R1 shift release unchanged", shift_lock, 0);

      // R2 short caps press
      caps_key = 1'b1; tick(5);
      chk("R2 caps on while held", caps_lock, 1);
      caps_key = 1'b0; tick(3);
      chk("R2 caps stays after short press", caps_lock, 1);
      chk("R5 caps led lit", caps_led_n, 0);
      chk("R4 no turbo short press", turbo, 0);

      // R3 / R4 long caps press from lock=1
      caps_key = 1'b1; tick(3);
      chk("R2 caps toggled off", caps_lock, 0);
      tick(HOLD - 4);
      chk("R3 turbo not yet", turbo, 0);
      chk("R3 caps still off before hold", caps_lock, 0);
      tick(2);
      chk("R3 turbo at hold", turbo, 1);
      chk("R3 caps restored", caps_lock, 1);
      tick(30);
      chk("R4 turbo held", turbo, 1);
      caps_key = 1'b0; tick(1);
      chk("R4 turbo drops on release", turbo, 0);
      chk("R3 caps kept after release", caps_lock, 1);

      // R8 host silence
      for (int k = 0; k < NC; k++) duty[k*8 +: 8] = 8'd0;
      tick(4);
      host_frame = 1'b0;
      tick(SILENT - 5);
      chk("R8 not absent before silence", int'(rgb_n), int'({NC{1'b1}}));
      tick(10);
      chk("R8 R9 flash after silence", int'(rgb_n), int'(flash_exp(1'b0)));
      host_frame = 1'b1; tick(1); host_frame = 1'b0; tick(2);
      chk("R8 single frame ends flash", int'(rgb_n), int'({NC{1'b1}}));

      // R1 reset mid-run
      rst_n = 1'b0; tick(2);
      chk("R1 reset clears caps", caps_lock, 0);
      rst_n = 1'b1; tick(2);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule